// File: doc/BRIEF.md
# I2C Serial EEPROM Target

This block models a byte-wide serial EEPROM that sits on an I2C bus as a target device. A fast system clock oversamples the open-drain SCL and SDA lines. The block answers only to its own target address. It takes a two-byte word address and then either collects write data or returns stored bytes. The device pulls SDA low through a single output enable. Outside logic turns this enable into the open-drain pad.

Write data does not go straight into the array. It is collected in a page-sized staging buffer and programmed only after the master ends the transfer with STOP. A self-timed programming window follows, and during it the device is deaf to the bus. Three strap inputs let up to eight devices share a bus. A write-protect input freezes the array. Reads return one byte at a time after a random address set-up, or a stream of bytes that runs on through the array.

Top module: `i2c_eeprom_target`

## Requirements
- R1: The target address byte is matched as bits [7:4] = 4'b1010, bits [3:1] = `strap_i`, bit 0 = read (1) or write (0). The device acknowledges, by holding SDA low during the ninth clock, only when type code and strap bits both match.
- R2: The word address follows the target address as two bytes, high byte first. Only the low 4 bits of the high byte are used, so the address is 12 bits wide.
- R3: A byte written to an address reads back unchanged once the programming window that follows its STOP has ended.
- R4: In a write sequence the low 5 address bits advance after each data byte and wrap within the 32-byte page. A later byte that lands on an offset already written replaces the earlier one, and only the offsets written are programmed.
- R5: Programming starts at the STOP that ends a write sequence holding at least one data byte. For `PROG_CYCLES` clocks the device leaves SDA released and does not acknowledge its target address.
- R6: After the programming window the device acknowledges its target address again without any outside action.
- R7: If `wp_i` is high at the STOP of a write sequence, no byte of the array changes and no programming window starts, so the device acknowledges its address at once.
- R8: A random read sets the address with a write-mode header, then a repeated START and a read-mode header. It returns the byte stored at that address.
- R9: In a read, each byte acknowledged by the master is followed by the byte at the next address. The address wraps from 12'hFFF to 12'h000. A NACK followed by STOP ends the read, and the device is then ready for a new header.
- R10: The device changes its SDA drive only while SCL is low. START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high.
- R11: Out of reset SDA is released and no programming window is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired-AND bus value) |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| strap_i | input | 3 | Address straps compared with target address bits [3:1] |
| wp_i | input | 1 | Write protect, high blocks all array updates |

## Verification
The address decoder is swept over all eight strap codes against a fixed strap setting, plus one wrong type code, so that each mismatching bit position is seen to give a NACK. The page write starts two bytes before the page end and runs three bytes past a full page. The read-back therefore shows wrap within the page rather than a carry into the next page, and shows that the last writer wins on overlapping offsets. A header with junk in the upper nibble of the high address byte, a protected write followed by an at-once poll, a poll inside the programming window, and a read that crosses the top of the array separate address decoding, write blocking, busy handling and read address wrap from one another.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_AHI, ST_ALO, ST_WR, ST_RD
  } bus_st_e;

  localparam logic [3:0] TYPE_CODE = 4'b1010;
endpackage

// File: rtl/i2c_line_mon.sv
module i2c_line_mon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_STAGES-1:0] scl_q, sda_q;
  logic scl_p, sda_p, scl_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[SYNC_STAGES-2:0], scl_i};
      sda_q <= {sda_q[SYNC_STAGES-2:0], sda_i};
      scl_p <= scl_q[SYNC_STAGES-1];
      sda_p <= sda_q[SYNC_STAGES-1];
    end
  end

  assign scl_s      = scl_q[SYNC_STAGES-1];
  assign sda_o      = sda_q[SYNC_STAGES-1];
  assign scl_rise_o = scl_s & ~scl_p;
  assign scl_fall_o = ~scl_s & scl_p;
  assign start_o    = scl_s & scl_p & sda_p & ~sda_o;
  assign stop_o     = scl_s & scl_p & ~sda_p & sda_o;
endmodule

// File: rtl/eeprom_page_buf.sv
module eeprom_page_buf #(
  parameter int PAGE_BYTES = 32,
  localparam int IDX_W = $clog2(PAGE_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  logic [7:0]       wdata_i,
  input  logic [IDX_W-1:0] ridx_i,
  output logic [7:0]       rdata_o,
  output logic             rvalid_o
);
  logic [7:0]            data_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    vld_q <= '0;
    else if (clr_i) vld_q <= '0;
    else if (we_i)  vld_q[widx_i] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (we_i) data_q[widx_i] <= wdata_i;
  end

  assign rdata_o  = data_q[ridx_i];
  assign rvalid_o = vld_q[ridx_i];
endmodule

// File: rtl/eeprom_prog_timer.sv
module eeprom_prog_timer #(
  parameter int PROG_CYCLES = 500000,
  parameter int PAGE_BYTES  = 32,
  localparam int IDX_W = $clog2(PAGE_BYTES),
  localparam int CNT_W = $clog2(PROG_CYCLES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             busy_o,
  output logic             we_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_o) begin
      if (start_i) begin
        busy_o <= 1'b1;
        cnt_q  <= '0;
      end
    end else if (cnt_q == CNT_W'(PROG_CYCLES - 1)) begin
      busy_o <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // one staged byte per clock at the head of the window
  assign we_o  = busy_o && (cnt_q < CNT_W'(PAGE_BYTES));
  assign idx_o = cnt_q[IDX_W-1:0];
endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
  import eeprom_pkg::*;
#(
  parameter int MEM_DEPTH   = 4096,
  parameter int PAGE_BYTES  = 32,
  parameter int PROG_CYCLES = 500000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic [2:0] strap_i,
  input  logic       wp_i
);
  localparam int ADDR_W = $clog2(MEM_DEPTH);
  localparam int IDX_W  = $clog2(PAGE_BYTES);
  localparam int HI_W   = ADDR_W - 8;
  localparam int PG_W   = ADDR_W - IDX_W;

  logic sda_s, scl_rise, scl_fall, start, stop;
  logic prog_busy, prog_we, buf_rvalid;
  logic [IDX_W-1:0] prog_idx;
  logic [7:0] buf_rdata, rd_byte;

  bus_st_e          st_q;
  logic             ack_slot_q, rd_mode_q, mack_q, wr_pend_q;
  logic [3:0]       bcnt_q;
  logic [7:0]       sh_q;
  logic [ADDR_W-1:0] addr_q;
  logic [PG_W-1:0]  commit_pg_q;
  logic [7:0]       mem_q [MEM_DEPTH];

  logic rx_st, byte_done, dev_match, buf_we, buf_clr, prog_start;

  i2c_line_mon #(.SYNC_STAGES(SYNC_STAGES)) u_line (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start), .stop_o(stop)
  );

  assign rx_st      = st_q inside {ST_DEV, ST_AHI, ST_ALO, ST_WR};
  assign byte_done  = rx_st && scl_fall && !ack_slot_q && bcnt_q == 4'd8;
  assign dev_match  = sh_q[7:4] == TYPE_CODE && sh_q[3:1] == strap_i;
  assign buf_we     = !prog_busy && !start && !stop && byte_done && st_q == ST_WR;
  assign buf_clr    = !prog_busy && !start && !stop && scl_fall && ack_slot_q
                      && st_q == ST_ALO;
  assign prog_start = stop && wr_pend_q && !wp_i && !prog_busy;

  eeprom_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
    .clk_i, .rst_ni, .clr_i(buf_clr), .we_i(buf_we),
    .widx_i(addr_q[IDX_W-1:0]), .wdata_i(sh_q),
    .ridx_i(prog_idx), .rdata_o(buf_rdata), .rvalid_o(buf_rvalid)
  );

  eeprom_prog_timer #(.PROG_CYCLES(PROG_CYCLES), .PAGE_BYTES(PAGE_BYTES)) u_prog (
    .clk_i, .rst_ni, .start_i(prog_start),
    .busy_o(prog_busy), .we_o(prog_we), .idx_o(prog_idx)
  );

  always_ff @(posedge clk_i) begin
    if (prog_we && buf_rvalid) mem_q[{commit_pg_q, prog_idx}] <= buf_rdata;
  end

  assign rd_byte = mem_q[addr_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      ack_slot_q  <= 1'b0;
      rd_mode_q   <= 1'b0;
      mack_q      <= 1'b1;
      wr_pend_q   <= 1'b0;
      bcnt_q      <= '0;
      sh_q        <= '0;
      addr_q      <= '0;
      commit_pg_q <= '0;
      sda_oe_o    <= 1'b0;
    end else if (prog_busy) begin
      st_q       <= ST_IDLE;
      ack_slot_q <= 1'b0;
      sda_oe_o   <= 1'b0;
    end else if (start) begin
      st_q       <= ST_DEV;
      bcnt_q     <= '0;
      ack_slot_q <= 1'b0;
      sda_oe_o   <= 1'b0;
    end else if (stop) begin
      st_q        <= ST_IDLE;
      ack_slot_q  <= 1'b0;
      sda_oe_o    <= 1'b0;
      wr_pend_q   <= 1'b0;
      commit_pg_q <= addr_q[ADDR_W-1:IDX_W];
    end else if (rx_st) begin
      if (scl_rise && !ack_slot_q && bcnt_q < 4'd8) begin
        sh_q   <= {sh_q[6:0], sda_s};
        bcnt_q <= bcnt_q + 1'b1;
      end
      if (byte_done) begin
        ack_slot_q <= 1'b1;
        sda_oe_o   <= 1'b1;
        case (st_q)
          ST_DEV: begin
            rd_mode_q <= sh_q[0];
            if (!dev_match) begin
              st_q       <= ST_IDLE;
              ack_slot_q <= 1'b0;
              sda_oe_o   <= 1'b0;
            end
          end
          ST_AHI:  addr_q[ADDR_W-1:8] <= sh_q[HI_W-1:0];
          ST_ALO:  addr_q[7:0] <= sh_q;
          default: begin
            wr_pend_q <= 1'b1;
            addr_q[IDX_W-1:0] <= addr_q[IDX_W-1:0] + 1'b1;
          end
        endcase
      end else if (scl_fall && ack_slot_q) begin
        ack_slot_q <= 1'b0;
        bcnt_q     <= '0;
        sda_oe_o   <= 1'b0;
        case (st_q)
          ST_DEV: begin
            if (rd_mode_q) begin
              st_q     <= ST_RD;
              sh_q     <= rd_byte;
              sda_oe_o <= ~rd_byte[7];
            end else begin
              st_q <= ST_AHI;
            end
          end
          ST_AHI:  st_q <= ST_ALO;
          ST_ALO:  st_q <= ST_WR;
          default: st_q <= ST_WR;
        endcase
      end
    end else if (st_q == ST_RD) begin
      if (scl_rise) begin
        if (ack_slot_q) mack_q <= sda_s;
        else            bcnt_q <= bcnt_q + 1'b1;
      end
      if (scl_fall) begin
        if (ack_slot_q) begin
          ack_slot_q <= 1'b0;
          if (!mack_q) begin
            sh_q     <= rd_byte;
            sda_oe_o <= ~rd_byte[7];
            bcnt_q   <= '0;
          end else begin
            st_q     <= ST_IDLE;
            sda_oe_o <= 1'b0;
          end
        end else if (bcnt_q == 4'd8) begin
          sda_oe_o   <= 1'b0;
          ack_slot_q <= 1'b1;
          addr_q     <= addr_q + 1'b1;
        end else begin
          sh_q     <= {sh_q[6:0], 1'b0};
          sda_oe_o <= ~sh_q[6];
        end
      end
    end
  end
endmodule

// File: rtl/eeprom_checker.sv
module eeprom_checker #(
  parameter int PROG_CYCLES = 500000
) (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_i,
  input logic sda_oe_o,
  input logic wp_i,
  input logic busy
);
  logic [31:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   run_q <= '0;
    else if (busy) run_q <= run_q + 1'b1;
    else           run_q <= '0;
  end

  p_sda_release_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !sda_oe_o);

  p_prog_length_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> run_q == 32'(PROG_CYCLES));

  p_wp_blocks_prog_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> !$past(wp_i));

  p_sda_steady_scl_high_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_i && $past(scl_i) |-> $stable(sda_oe_o));
endmodule

bind i2c_eeprom_target eeprom_checker #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_oe_o(sda_oe_o),
  .wp_i(wp_i), .busy(prog_busy)
);

// File: tb/tb_i2c_eeprom_target.sv
`timescale 1ns/1ps
module tb_i2c_eeprom_target;
  localparam int PROG = 400;
  localparam int H    = 8;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, wp = 1'b0;
  logic sda_oe;
  logic sda_bus;
  int n_chk = 0, n_bad = 0, viol = 0;
  bit done = 1'b0;
  logic prev_scl = 1'b1, prev_oe = 1'b0;

  always #4 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  i2c_eeprom_target #(.PROG_CYCLES(PROG)) dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .strap_i(STRAP), .wp_i(wp)
  );

  // R10 monitor: drive edges only while SCL low
  always @(negedge clk) begin
    if (rst_n && scl_m && prev_scl && sda_oe != prev_oe) viol++;
    prev_scl = scl_m;
    prev_oe  = sda_oe;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic i2c_start;
    sda_m = 1'b1; tick(H);
    scl_m = 1'b1; tick(H);
    sda_m = 1'b0; tick(H);
    scl_m = 1'b0; tick(H);
  endtask

  task automatic i2c_stop;
    sda_m = 1'b0; tick(H);
    scl_m = 1'b1; tick(H);
    sda_m = 1'b1; tick(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(H);
      scl_m = 1'b1; tick(H);
      scl_m = 1'b0; tick(H);
    end
    sda_m = 1'b1; tick(H);
    scl_m = 1'b1; tick(H/2);
    ack = !sda_bus;
    tick(H/2);
    scl_m = 1'b0; tick(H);
  endtask

  task automatic recv_byte(input bit nack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(H);
      scl_m = 1'b1; tick(H/2);
      b[i] = sda_bus;
      tick(H/2);
      scl_m = 1'b0;
    end
    tick(H);
    sda_m = nack; tick(H);
    scl_m = 1'b1; tick(H);
    scl_m = 1'b0; tick(H);
    sda_m = 1'b1;
  endtask

  task automatic poll(output bit ack);
    i2c_start;
    send_byte({4'hA, STRAP, 1'b0}, ack);
    i2c_stop;
  endtask

  task automatic set_addr(input logic [7:0] hi, input logic [7:0] lo);
    bit a;
    i2c_start;
    send_byte({4'hA, STRAP, 1'b0}, a);
    send_byte(hi, a);
    send_byte(lo, a);
  endtask

  task automatic write_one(input logic [7:0] hi, input logic [7:0] lo,
                           input logic [7:0] d);
    bit a;
    set_addr(hi, lo);
    send_byte(d, a);
    i2c_stop;
  endtask

  task automatic read_start(input logic [7:0] hi, input logic [7:0] lo);
    bit a;
    set_addr(hi, lo);
    i2c_start;
    send_byte({4'hA, STRAP, 1'b1}, a);
  endtask

  initial begin
    bit ack;
    logic [7:0] d;
    logic [7:0] exp_pg [32];

    tick(5);
    chk("R11 sda released in reset", int'(sda_oe), 0);
    rst_n = 1'b1; tick(5);
    chk("R11 sda released after reset", int'(sda_oe), 0);

    // R1: strap sweep and wrong type code
    for (int s = 0; s < 8; s++) begin
      i2c_start;
      send_byte({4'hA, 3'(s), 1'b0}, ack);
      i2c_stop;
      chk($sformatf("R1 strap code %0d", s), int'(ack), int'(3'(s) == STRAP));
    end
    i2c_start;
    send_byte({4'hB, STRAP, 1'b0}, ack);
    i2c_stop;
    chk("R1 wrong type code", int'(ack), 0);

    // R2 R3 R5 R6: byte write with junk high nibble
    write_one(8'hF1, 8'h23, 8'hA5);
    poll(ack);
    chk("R5 no ack while programming", int'(ack), 0);
    tick(PROG + 50);
    poll(ack);
    chk("R6 ack after programming", int'(ack), 1);
    read_start(8'h01, 8'h23);
    recv_byte(1'b1, d); i2c_stop;
    chk("R3 R8 byte write readback", int'(d), 'hA5);
    read_start(8'h51, 8'h23);
    recv_byte(1'b1, d); i2c_stop;
    chk("R2 upper nibble ignored", int'(d), 'hA5);

    // R4: page write from offset 30, 35 bytes, wraps in page
    set_addr(8'h02, 8'h5E);
    for (int k = 0; k < 35; k++) begin
      send_byte(8'(8'h40 + k), ack);
      exp_pg[(30 + k) % 32] = 8'(8'h40 + k);
    end
    i2c_stop;
    tick(PROG + 50);
    read_start(8'h02, 8'h40);
    for (int k = 0; k < 32; k++) begin
      recv_byte(k == 31, d);
      chk($sformatf("R4 page offset %0d", k), int'(d), int'(exp_pg[k]));
    end
    i2c_stop;

    // R7: protected write
    wp = 1'b1;
    write_one(8'h01, 8'h23, 8'h77);
    wp = 1'b0;
    poll(ack);
    chk("R7 no programming window", int'(ack), 1);
    read_start(8'h01, 8'h23);
    recv_byte(1'b1, d); i2c_stop;
    chk("R7 array unchanged", int'(d), 'hA5);

    // R9: sequential read across top of array
    write_one(8'h0F, 8'hFF, 8'h11);
    tick(PROG + 50);
    write_one(8'h00, 8'h00, 8'h22);
    tick(PROG + 50);
    read_start(8'h0F, 8'hFF);
    recv_byte(1'b0, d);
    chk("R9 last address", int'(d), 'h11);
    recv_byte(1'b1, d);
    i2c_stop;
    chk("R9 wrap to zero", int'(d), 'h22);
    poll(ack);
    chk("R9 ready after nack stop", int'(ack), 1);

    chk("R10 sda changes only with scl low", viol, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule